// File: doc/BRIEF.md
# LPC Host I/O Address Matcher

This block decides whether a host I/O cycle on an LPC-style bus is aimed at one host-interface channel. The local CPU programs a 16-bit base through two byte-wide halves of an address/control register. The low bit of that register does not take part in address comparison. It enables a second decode window. The host side delivers an address that has already been decoded from the bus framing, together with a direction bit and a valid strobe. The matcher answers one cycle later with registered hit flags.

There are two windows, and both come from the same base. The first covers the channel's data and status registers. In that window, bit 0 of the base counts as 0, address bit 2 is a don't-care, and address bit 0 chooses data or status. The matcher also raises one-cycle event pulses for an input-data write, an output-data read and a status read. The second window covers a bank of sixteen bidirectional data registers. It inverts base bit 4, ignores the low address nibble and returns that nibble as the bank index. This window only works while the register's bank-enable bit is set.

While the channel enable is high, the address field is write-protected. The bank-enable bit stays writable at all times.

Top module: `lpc_io_addr_match`

## Requirements
- R1: After reset, both register bytes read 0x00 and all hit flags, pulses and the bank index are 0.
- R2: While `chan_en` is 0, a CPU write stores the full byte in the half picked by `cpu_sel` (1 = high byte for bits 15..8, 0 = low byte for bits 7..0), and `cpu_rdata` returns it. This includes reserved bit 2 of the low byte.
- R3: While `chan_en` is 0, no host access produces any hit or pulse.
- R4: A data/status hit occurs when the address matches the base on bits 15..3 and bit 1. Address bit 2 and bit 0 are ignored, and base bit 0 is treated as 0.
- R5: On a data/status hit, address bit 0 = 0 selects data and 1 selects status. A data write pulses `idw_pulse`, a data read pulses `odr_pulse`, a status read pulses `str_pulse`, and a status write pulses none of them.
- R6: A bank hit occurs when address bits 15..4 equal base bits 15..5 followed by inverted base bit 4. `bank_idx` then equals address bits 3..0; otherwise it is 0.
- R7: When low-byte bit 0 (bank enable) is 0, `hit_bank` never rises.
- R8: While `chan_en` is 1, writes leave address bits 15..1 unchanged (reserved bit 2 included), but bank-enable bit 0 still takes the written value.
- R9: Outputs rise in the cycle after the clock edge that samples `host_valid` and last one cycle per valid beat. Without a valid beat, they stay 0.
- R10: At most one of `hit_ds` and `hit_bank` is set, and the data/status hit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; gates matching and locks the address field |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_sel | input | 1 | Byte select: 1 high byte, 0 low byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read-back of the selected byte |
| host_valid | input | 1 | Host I/O address valid strobe |
| host_write | input | 1 | Host direction: 1 write, 0 read |
| host_addr | input | 16 | Host I/O address |
| hit_ds | output | 1 | Registered data/status hit |
| hit_bank | output | 1 | Registered bank hit |
| bank_idx | output | 4 | Registered bank register index |
| idw_pulse | output | 1 | Host wrote the data register |
| odr_pulse | output | 1 | Host read the data register |
| str_pulse | output | 1 | Host read the status register |

## Verification
The bench uses one base and applies a table of addresses to it:
- Data and status addresses, in both directions and with bit 2 flipped, separate the ignored bit from the compared bits.
- Bank addresses at index 0, 15 and a middle value confirm that the bit-4 inversion and the index pass-through are correct.
- Near-miss addresses that differ only in bit 1, bit 3, bit 4 or a high bit show that none of these is accidentally masked.

Directed cases then cover:
- disabling the channel;
- clearing the bank enable;
- attempting address writes while the channel is live;
- back-to-back valid beats, which separate per-beat registration from held state.

// File: rtl/lpcm_pkg.sv
package lpcm_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int BANK_EN_BIT = 0;
  localparam int BANK_FLIP_BIT = 4;

  // address bits not compared in the data/status window (bit 0 selects, bit 2 free)
  localparam logic [ADDR_W-1:0] DS_DONTCARE   = ADDR_W'(5);
  // address bits not compared in the bank window (low nibble is the index)
  localparam logic [ADDR_W-1:0] BANK_DONTCARE = ADDR_W'((1 << IDX_W) - 1);
  localparam logic [ADDR_W-1:0] BANK_FLIP     = ADDR_W'(1 << BANK_FLIP_BIT);

  function automatic logic ds_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] care;
    care = ~DS_DONTCARE;
    return (addr & care) == (base & care);
  endfunction

  function automatic logic bank_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] care;
    care = ~BANK_DONTCARE;
    return (addr & care) == ((base ^ BANK_FLIP) & care);
  endfunction
endpackage

// File: rtl/lpcm_basereg.sv
module lpcm_basereg
  import lpcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] base
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic wr_hi, wr_lo, addr_locked;

  assign addr_locked = chan_en;
  assign wr_hi = cpu_we &&  cpu_sel;
  assign wr_lo = cpu_we && !cpu_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi && !addr_locked) hi_q <= cpu_wdata;
      if (wr_lo) begin
        if (!addr_locked) lo_q <= cpu_wdata;
        else lo_q[BANK_EN_BIT] <= cpu_wdata[BANK_EN_BIT];
      end
    end
  end

  assign base      = {hi_q, lo_q};
  assign cpu_rdata = cpu_sel ? hi_q : lo_q;

  // R8
  addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_locked && cpu_we) |=> (base[ADDR_W-1:1] == $past(base[ADDR_W-1:1])));

  // R8
  en_bit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (base[BANK_EN_BIT] == $past(cpu_wdata[BANK_EN_BIT])));
endmodule

// File: rtl/lpcm_decode.sv
module lpcm_decode
  import lpcm_pkg::*;
(
  input  logic              chan_en,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ADDR_W-1:0] base,
  output logic              ds_sel,
  output logic              bank_sel,
  output logic [IDX_W-1:0]  idx
);
  logic ds_raw, bank_raw, bank_on;

  assign ds_raw   = ds_window(host_addr, base);
  assign bank_raw = bank_window(host_addr, base);
  assign bank_on  = base[BANK_EN_BIT];

  always_comb begin
    ds_sel   = host_valid && chan_en && ds_raw;
    bank_sel = host_valid && chan_en && bank_on && bank_raw && !ds_raw;
    idx      = bank_sel ? host_addr[IDX_W-1:0] : '0;
  end

  // R10
  always_comb begin
    one_window_chk: assert (!(ds_sel && bank_sel));
  end
endmodule

// File: rtl/lpc_io_addr_match.sv
module lpc_io_addr_match
  import lpcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              hit_ds,
  output logic              hit_bank,
  output logic [IDX_W-1:0]  bank_idx,
  output logic              idw_pulse,
  output logic              odr_pulse,
  output logic              str_pulse
);
  logic [ADDR_W-1:0] base;
  logic ds_sel, bank_sel, is_status;
  logic [IDX_W-1:0] idx;

  lpcm_basereg u_reg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cpu_we(cpu_we),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .base(base)
  );

  lpcm_decode u_dec (
    .chan_en(chan_en), .host_valid(host_valid), .host_addr(host_addr),
    .base(base), .ds_sel(ds_sel), .bank_sel(bank_sel), .idx(idx)
  );

  assign is_status = host_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_ds    <= 1'b0;
      hit_bank  <= 1'b0;
      bank_idx  <= '0;
      idw_pulse <= 1'b0;
      odr_pulse <= 1'b0;
      str_pulse <= 1'b0;
    end else begin
      hit_ds    <= ds_sel;
      hit_bank  <= bank_sel;
      bank_idx  <= idx;
      idw_pulse <= ds_sel && !is_status &&  host_write;
      odr_pulse <= ds_sel && !is_status && !host_write;
      str_pulse <= ds_sel &&  is_status && !host_write;
    end
  end

  // R3
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !(hit_ds || hit_bank));

  // R9
  no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> !(hit_ds || hit_bank || idw_pulse || odr_pulse || str_pulse));

  // R7
  bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base[BANK_EN_BIT] |=> !hit_bank);

  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idw_pulse || odr_pulse || str_pulse) |-> hit_ds);

  // R5
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idw_pulse, odr_pulse, str_pulse}));

  // R10
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ds, hit_bank}));

  // R6
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_bank |-> (bank_idx == '0));
endmodule

// File: tb/lpc_io_addr_match_test.sv
module lpc_io_addr_match_test;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [15:0] host_addr = '0;
  logic hit_ds, hit_bank, idw_pulse, odr_pulse, str_pulse;
  logic [3:0] bank_idx;

  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  lpc_io_addr_match uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cpu_we(cpu_we),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .hit_ds(hit_ds), .hit_bank(hit_bank), .bank_idx(bank_idx),
    .idw_pulse(idw_pulse), .odr_pulse(odr_pulse), .str_pulse(str_pulse)
  );

  typedef struct packed {
    logic [15:0] addr; logic wr; logic ds; logic bk; logic [3:0] idx;
    logic idw; logic odr; logic str;
  } vec_t;

  // base = 0x0CA3 (bank enable set): data/status at 0x0CA2/3/6/7, bank 0x0CB0..0x0CBF
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0CA2, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0},
    '{16'h0CA2, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
    '{16'h0CA3, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1},
    '{16'h0CA3, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h0CA6, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
    '{16'h0CA7, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1},
    '{16'h0CB0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h0CBF, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0},
    '{16'h0CB5, 1'b0, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0},
    '{16'h0CA0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h0CA8, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h1CA2, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h0CC5, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
    '{16'h0CA1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [8:0] outs();
    return {hit_ds, hit_bank, bank_idx, idw_pulse, odr_pulse, str_pulse};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel;
    #1 d = cpu_rdata;
  endtask

  // one valid beat; returns outputs seen in the cycle after the sampling edge
  task automatic host_beat(input logic [15:0] a, input logic wr, output logic [8:0] o);
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_write = wr;
    @(negedge clk);
    host_valid = 1'b0;
    o = outs();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [8:0] o;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs", {7'b0, outs()}, 16'h0);
    cpu_read(1'b1, rd); check("R1 high byte", {8'h0, rd}, 16'h0);
    cpu_read(1'b0, rd); check("R1 low byte", {8'h0, rd}, 16'h0);
    rst_n = 1'b1;

    // R2: byte storage including reserved bit 2
    cpu_write(1'b0, 8'h07);
    cpu_read(1'b0, rd); check("R2 low byte reserved bit", {8'h0, rd}, 16'h0007);
    cpu_write(1'b1, 8'h0C);
    cpu_write(1'b0, 8'hA3);
    cpu_read(1'b1, rd); check("R2 high byte", {8'h0, rd}, 16'h000C);
    cpu_read(1'b0, rd); check("R2 low byte", {8'h0, rd}, 16'h00A3);

    // R3: channel disabled
    host_beat(16'h0CA2, 1'b1, o); check("R3 ds off", {7'b0, o}, 16'h0);
    host_beat(16'h0CB4, 1'b0, o); check("R3 bank off", {7'b0, o}, 16'h0);

    // R4 R5 R6 R10: vector table
    chan_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      host_beat(VECS[i].addr, VECS[i].wr, o);
      check($sformatf("R4/R5/R6 vec %0d", i), {7'b0, o},
            {7'b0, VECS[i].ds, VECS[i].bk, VECS[i].idx, VECS[i].idw, VECS[i].odr, VECS[i].str});
      check($sformatf("R10 vec %0d", i), {15'b0, o[8] & o[7]}, 16'h0);
    end

    // R9: one cycle wide, and back-to-back beats each registered
    host_beat(16'h0CA2, 1'b0, o);
    @(negedge clk);
    check("R9 drops after one cycle", {7'b0, outs()}, 16'h0);
    @(negedge clk);
    host_valid = 1'b1; host_addr = 16'h0CA3; host_write = 1'b0;
    @(negedge clk);
    host_addr = 16'h0CB1;
    check("R9 first beat", {7'b0, outs()}, {7'b0, 1'b1, 1'b0, 4'h0, 3'b001});
    @(negedge clk);
    host_valid = 1'b0;
    check("R9 second beat", {7'b0, outs()}, {7'b0, 1'b0, 1'b1, 4'h1, 3'b000});
    @(negedge clk);
    check("R9 idle after beats", {7'b0, outs()}, 16'h0);

    // R8: address locked while enabled, enable bit still writable
    cpu_write(1'b1, 8'h55);
    cpu_read(1'b1, rd); check("R8 high locked", {8'h0, rd}, 16'h000C);
    cpu_write(1'b0, 8'h04);
    cpu_read(1'b0, rd); check("R8 low locked, en cleared", {8'h0, rd}, 16'h00A2);
    // R7: bank disabled
    host_beat(16'h0CB3, 1'b0, o); check("R7 bank disabled", {7'b0, o}, 16'h0);
    host_beat(16'h0CA2, 1'b1, o);
    check("R8 base intact ds hit", {7'b0, o}, {7'b0, 1'b1, 1'b0, 4'h0, 3'b100});
    cpu_write(1'b0, 8'hFF);
    cpu_read(1'b0, rd); check("R8 en set under lock", {8'h0, rd}, 16'h00A3);
    host_beat(16'h0CB3, 1'b0, o);
    check("R7 bank re-enabled", {7'b0, o}, {7'b0, 1'b0, 1'b1, 4'h3, 3'b000});

    finish_run();
  end
endmodule